// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits inside an SDRAM-style memory controller. It holds the programmable mode word that sets burst length, burst ordering, CAS latency and write burst behaviour. On every READ or WRITE command it turns the starting column into the sequence of column addresses the burst visits, giving one address per clock. A mode load carrying an unsupported encoding, or arriving while any bank is busy, is refused and flagged, and the previous mode word stays in force.

Fixed-length bursts of 2, 4 or 8 beats stay inside an aligned block of that many columns. The starting column's low bits pick the entry point, and the address wraps at the block edge in either ascending (sequential) or XOR (interleaved) order. A full-page burst walks upward through the 256-column page, wraps from the top column to zero, and runs until a terminate strobe or a new command stops it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: In sequential mode (mode bit 3 = 0) with length code 001, 010 or 011 in mode bits 2:0 (2, 4 or 8 beats), beat i of a burst from column S has address (S with its low log2(BL) bits cleared) OR ((S + i) mod BL).
- R2: In interleaved mode (mode bit 3 = 1), beat i has address (S with its low log2(BL) bits cleared) OR ((S XOR i) mod BL).
- R3: `col_last` is high on the final beat of a fixed-length burst and only then. `col_vld` is low in the cycle after that beat unless a new command arrives. Length code 000 gives a single beat at S.
- R4: Length code 111 with sequential order gives a full-page burst. Its addresses step by one modulo 256, it never raises `col_last`, and a `term` pulse ends it so that `col_vld` is low on the next cycle.
- R5: With mode bit 9 = 1, a WRITE (`cmd_wr` = 1) produces a single beat. READs keep the programmed length. With bit 9 = 0, writes also use the programmed length.
- R6: `cas_lat` shows 2 for latency code 010 and 3 for code 011 in mode bits 6:4.
- R7: A mode load is refused if any of these holds: length code 100, 101 or 110; length 111 together with bit 3 = 1; latency code other than 010 or 011; bits 8:7 not 00; bits 11:10 not 00. A refused load raises `mode_err` for exactly the following cycle and leaves the mode word unchanged.
- R8: A mode load while `all_idle` is low is refused in the same way as R7, even if its value is legal.
- R9: A command that arrives during a burst abandons the old burst. The new burst's first address appears on the next cycle.
- R10: After reset, `col_vld`, `col_last` and `mode_err` are low and the mode is single-beat sequential with CAS latency 2.
- R11: The first address of a burst appears in the cycle after the clock edge that samples `cmd_vld`. Each later beat follows one cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ld | input | 1 | Mode load strobe |
| mode_val | input | 12 | Mode value to load |
| all_idle | input | 1 | High when every bank is idle |
| cmd_vld | input | 1 | READ/WRITE command strobe |
| cmd_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | COL_W | Starting column of the burst |
| term | input | 1 | Burst terminate strobe |
| col_out | output | COL_W | Column address of the current beat |
| col_vld | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err | output | 1 | Previous-cycle mode load was refused |

## Verification
The case hardest to reach from the ports is a full-page burst crossing the page end: it only shows up after a couple of hundred beats with no command and no terminate. The stimulus starts full-page bursts near the top of the page and holds them for longer than a whole page before terminating. The reject path for every reserved encoding is reached by sweeping all 4096 mode values, with `all_idle` dropped on a fixed subset. Fixed-length bursts in both orders are run from every one of the 256 start columns, and a restart is forced in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int MODE_W = 12;

    typedef struct packed {
        logic [2:0] len;        // length code, already validated
        logic       ilv;        // interleaved order
        logic       cl3;        // CAS latency 3 (else 2)
        logic       wb_single;  // writes are single-location
    } mode_t;

    localparam mode_t MODE_RST = '{len: 3'b000, ilv: 1'b0, cl3: 1'b0, wb_single: 1'b0};

    function automatic logic mode_legal(input logic [MODE_W-1:0] v);
        logic len_ok;
        logic cl_ok;
        len_ok = (v[2:0] <= 3'b011) || ((v[2:0] == 3'b111) && !v[3]);
        cl_ok  = (v[6:4] == 3'b010) || (v[6:4] == 3'b011);
        return len_ok && cl_ok && (v[8:7] == 2'b00) && (v[11:10] == 2'b00);
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [MODE_W-1:0] val,
    input  logic              all_idle,
    output mode_t             mode_o,
    output logic              err_o
);

    typedef struct packed {
        mode_t mode;
        logic  err;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (ld) begin
            if (all_idle && mode_legal(val)) begin
                st_d.mode.len       = val[2:0];
                st_d.mode.ilv       = val[3];
                st_d.mode.cl3       = (val[6:4] == 3'b011);
                st_d.mode.wb_single = val[9];
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RST, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign err_o  = st_q.err;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_i,
    input  logic             cmd_vld,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             term,
    output logic [COL_W-1:0] start_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             vld_o,
    output logic             last_o
);

    typedef struct packed {
        logic             active;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] cnt;
    } seq_t;

    seq_t             st_d, st_q;
    logic [COL_W-1:0] new_mask;
    logic             new_full;
    logic             single;
    logic             at_end;

    // block mask for the programmed length: low len bits set, all set for full page
    always_comb begin
        single   = cmd_wr && mode_i.wb_single;
        new_full = (mode_i.len == 3'b111) && !single;
        for (int b = 0; b < COL_W; b++) begin
            new_mask[b] = new_full || (!single && (b < int'(mode_i.len)));
        end
    end

    assign at_end = st_q.active && !st_q.full && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (cmd_vld) begin
            st_d.active = 1'b1;
            st_d.full   = new_full;
            st_d.ilv    = mode_i.ilv;
            st_d.mask   = new_mask;
            st_d.start  = cmd_col;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (term || at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign cnt_o   = st_q.cnt;
    assign mask_o  = st_q.mask;
    assign ilv_o   = st_q.ilv;
    assign vld_o   = st_q.active;
    assign last_o  = at_end;

endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] offs;

    always_comb begin
        offs = ilv ? (start ^ cnt) : (start + cnt);
        col  = (start & ~mask) | (offs & mask);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              all_idle,
    input  logic              cmd_vld,
    input  logic              cmd_wr,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              term,
    output logic [COL_W-1:0]  col_out,
    output logic              col_vld,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic              mode_err
);

    mode_t            mode;
    logic [COL_W-1:0] seq_start;
    logic [COL_W-1:0] seq_cnt;
    logic [COL_W-1:0] seq_mask;
    logic             seq_ilv;

    burst_mode_reg i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (mode_ld),
        .val      (mode_val),
        .all_idle (all_idle),
        .mode_o   (mode),
        .err_o    (mode_err)
    );

    burst_seq #(.COL_W(COL_W)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .cmd_vld (cmd_vld),
        .cmd_wr  (cmd_wr),
        .cmd_col (cmd_col),
        .term    (term),
        .start_o (seq_start),
        .cnt_o   (seq_cnt),
        .mask_o  (seq_mask),
        .ilv_o   (seq_ilv),
        .vld_o   (col_vld),
        .last_o  (col_last)
    );

    burst_col_calc #(.COL_W(COL_W)) i_calc (
        .start (seq_start),
        .cnt   (seq_cnt),
        .mask  (seq_mask),
        .ilv   (seq_ilv),
        .col   (col_out)
    );

    assign cas_lat = mode.cl3 ? 2'd3 : 2'd2;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_ld,
    input logic             all_idle,
    input logic             cmd_vld,
    input logic             term,
    input logic [COL_W-1:0] col_out,
    input logic             col_vld,
    input logic             col_last,
    input logic [1:0]       cas_lat,
    input logic             mode_err
);

    // R11: a command always yields a beat on the next cycle
    a_r11_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> col_vld);

    // R3: the final beat ends the burst unless a command follows
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_vld) |=> !col_vld);

    // R3: last flag only accompanies a valid beat
    a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_vld);

    // R4: terminate stops the burst
    a_r4_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !cmd_vld) |=> !col_vld);

    // R7: a refusal leaves the latency unchanged
    a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $stable(cas_lat));

    // R8: load while banks are busy is refused
    a_r8_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ld && !all_idle) |=> mode_err);

    // R7: error only follows a load
    a_r7_err_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(mode_ld));

    // R6: latency is always 2 or 3
    a_r6_cl_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 2'd2) || (cas_lat == 2'd3));

    logic unused_ok;
    assign unused_ok = ^col_out;

endmodule

bind sdram_burst_colgen burst_colgen_chk #(.COL_W(COL_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_ld  (mode_ld),
    .all_idle (all_idle),
    .cmd_vld  (cmd_vld),
    .term     (term),
    .col_out  (col_out),
    .col_vld  (col_vld),
    .col_last (col_last),
    .cas_lat  (cas_lat),
    .mode_err (mode_err)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_ld = 1'b0;
    logic [11:0]      mode_val = '0;
    logic             all_idle = 1'b1;
    logic             cmd_vld = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             term = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_vld;
    logic             col_last;
    logic [1:0]       cas_lat;
    logic             mode_err;

    int checks = 0;
    int errors = 0;
    int exp_cl = 2;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_val(mode_val),
        .all_idle(all_idle), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
        .term(term), .col_out(col_out), .col_vld(col_vld), .col_last(col_last),
        .cas_lat(cas_lat), .mode_err(mode_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit legal(input logic [11:0] v);
        bit len_ok;
        len_ok = (v[2:0] <= 3) || (v[2:0] == 7 && !v[3]);
        return len_ok && (v[6:4] == 2 || v[6:4] == 3) && v[8:7] == 0 && v[11:10] == 0;
    endfunction

    // load a mode value; check error flag and latency the cycle after
    task automatic load(input logic [11:0] v, input logic idle);
        bit ok;
        ok = legal(v) && idle;
        mode_ld = 1'b1; mode_val = v; all_idle = idle;
        @(negedge clk);
        mode_ld = 1'b0; all_idle = 1'b1;
        if (ok) exp_cl = (v[6:4] == 3) ? 3 : 2;
        chk(idle ? "R7 mode_err" : "R8 mode_err", mode_err, ok ? 0 : 1);
        chk("R6 cas_lat", cas_lat, exp_cl);
    endtask

    task automatic issue(input logic wr, input logic [COL_W-1:0] c);
        cmd_vld = 1'b1; cmd_wr = wr; cmd_col = c;
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    function automatic int exp_col(input int s, input int i, input int bl, input bit ilv);
        int m;
        m = bl - 1;
        return (s & ~m & 255) | ((ilv ? (s ^ i) : (s + i)) & m);
    endfunction

    // check a fixed-length burst already issued; ends one cycle after the last beat
    task automatic run_fixed(input string req, input int s, input int bl, input bit ilv);
        for (int i = 0; i < bl; i++) begin
            chk({req, " col_vld"}, col_vld, 1);
            chk({req, " col_out"}, col_out, exp_col(s, i, bl, ilv));
            chk("R3 col_last", col_last, (i == bl - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R3 idle after last", col_vld, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 col_vld", col_vld, 0);
        chk("R10 col_last", col_last, 0);
        chk("R10 mode_err", mode_err, 0);
        chk("R10 cas_lat", cas_lat, 2);
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b0, 8'd77);
        run_fixed("R10 default single", 77, 1, 0);

        // R7 / R8 / R6: every mode value, busy on a subset
        for (int v = 0; v < 4096; v++) begin
            load(v[11:0], (v % 7) != 3);
        end

        // R1 / R2 / R3 / R11: all lengths, both orders, every start column
        for (int t = 0; t < 2; t++) begin
            for (int code = 0; code < 4; code++) begin
                load({2'b00, 1'b0, 2'b00, 3'b011, t[0], code[2:0]}, 1'b1);
                for (int s = 0; s < 256; s++) begin
                    issue(1'b0, s[7:0]);
                    run_fixed(t == 0 ? "R1 seq" : "R2 ilv", s, 1 << code, t[0]);
                end
            end
        end

        // R5: write burst mode
        load(12'h223, 1'b1);
        issue(1'b1, 8'd45);
        run_fixed("R5 single write", 45, 1, 0);
        issue(1'b0, 8'd45);
        run_fixed("R5 read keeps length", 45, 8, 0);
        load(12'h023, 1'b1);
        issue(1'b1, 8'd45);
        run_fixed("R5 write uses length", 45, 8, 0);

        // R9: restart mid-burst
        issue(1'b0, 8'd21);
        for (int i = 0; i < 3; i++) begin
            chk("R9 first burst", col_out, exp_col(21, i, 8, 0));
            if (i < 2) @(negedge clk);
        end
        issue(1'b0, 8'd102);
        run_fixed("R9 restarted", 102, 8, 0);

        // R4: full page across the page end, then terminate
        load(12'h027, 1'b1);
        for (int k = 0; k < 3; k++) begin
            int s;
            s = 200 + k * 27;
            issue(1'b0, s[7:0]);
            for (int i = 0; i < 300; i++) begin
                chk("R4 page col", col_out, (s + i) % 256);
                chk("R4 page no last", col_last, 0);
                chk("R4 page vld", col_vld, 1);
                if (i < 299) @(negedge clk);
            end
            term = 1'b1;
            @(negedge clk);
            term = 1'b0;
            chk("R4 term stops", col_vld, 0);
        end
        load(12'h02F, 1'b1);
        chk("R7 page interleaved refused cl", cas_lat, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule